// File: doc/BRIEF.md
# Configuration Start-Up Event Sequencer

Once a configuration load has delivered its full length count, three start-up events must happen in a chosen order. The events are letting go of the open-drain DONE line, ending the global set/reset of user flip-flops, and enabling the user I/O. This block times each event by counting rising edges of its clock after the length-count-met pulse. Each of the two user-side events can be placed on a fixed edge after the length count. It can also follow the DONE line as observed on the board. As a third choice, it can be armed on a fixed edge and then held until the observed DONE line goes high, followed by a programmable extra delay of zero to four edges.

The DONE line is wire-ANDed with other devices, so any of them can hold it low and keep the DONE-dependent events from firing. The observed level is passed through a two-flop synchronizer before it is used. All outputs are sticky until program or reset. A finished flag reports that all three events have occurred. The program input returns the block to its pre-start-up state at any time.

The top-level controller has three states. SQ_IDLE moves to SQ_RUN on a length-count pulse. SQ_RUN moves to SQ_FIN once all three events have fired. Program moves any state back to SQ_IDLE. Each event has its own machine with four states. EV_WAIT moves to EV_FIRED on its trigger, or to EV_ARMED in synchronized mode. EV_ARMED moves to EV_FIRED, or to EV_HOLD when a delay is set, once the synchronized DONE is seen high. EV_HOLD moves to EV_FIRED after the delay. Program moves every state back to EV_WAIT.

Top module: `startup_sequencer`

## Requirements
- R1: After reset or program all four outputs are low, and no event fires until a new length-count pulse is sampled; any number of idle edges without that pulse leaves every output low.
- R2: The rising edge that samples lc_met_i high is edge 0 and the following edges are numbered 1, 2, 3 and so on; a further length-count pulse while the sequence runs is ignored and does not renumber the edges.
- R3: done_rel_o rises on edge n+1, where n is the value of done_sel_i (0 to 3).
- R4: With sel bit 2 clear and sync_en_i low, gsr_rel_o (selected by gsr_sel_i) or ioe_en_o (selected by ioe_sel_i) rises on edge m+1, where m is sel[1:0].
- R5: With sel bit 2 set, the event follows the DONE line. It rises on the first edge at which the synchronized copy of done_pin_i is high, which is the third rising edge after the pin goes high. sync_en_i and the event's delay input have no effect in this mode.
- R6: With sel bit 2 clear and sync_en_i high, the event is armed on edge m+1. From the first later edge at which the synchronized pin is high, it rises after d further edges, where d is its delay input (gsr_dly_i or ioe_dly_i); delay values above 4 act as 4.
- R7: While done_pin_i is held low externally, events that follow or synchronize to DONE do not fire, while done_rel_o still rises on its own edge.
- R8: Each of done_rel_o, gsr_rel_o and ioe_en_o stays high once set, until program or reset.
- R9: finished_o rises one edge after the last of the three event outputs rises and is only high while all three are high.
- R10: prog_i sampled high on any edge clears all four outputs on that edge, whatever the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock; all timing counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_i | input | 1 | Synchronous program request; returns to pre-start-up state |
| lc_met_i | input | 1 | Length-count-met pulse that starts the sequence |
| done_pin_i | input | 1 | Observed level of the wire-ANDed DONE line (asynchronous) |
| done_sel_i | input | 2 | DONE release edge, value n gives edge n+1 |
| gsr_sel_i | input | 3 | Set/reset release select: bit 2 follows DONE, else edge sel[1:0]+1 |
| ioe_sel_i | input | 3 | I/O enable select, same encoding as gsr_sel_i |
| sync_en_i | input | 1 | Synchronize edge-timed user events to the DONE line |
| gsr_dly_i | input | 3 | Extra edges after synchronized DONE for set/reset release (max 4) |
| ioe_dly_i | input | 3 | Extra edges after synchronized DONE for I/O enable (max 4) |
| done_rel_o | output | 1 | High releases the open-drain DONE driver |
| gsr_rel_o | output | 1 | High ends the global set/reset |
| ioe_en_o | output | 1 | High takes user I/O out of tristate |
| finished_o | output | 1 | All three events have occurred |

## Verification
The bench models the wire-AND with a hold-off that it controls. It measures the edge on which each output first rises against numbers worked out by hand. The aim is the synchronizer latency. A design that skipped a stage, or looked at the raw pin, would release DONE-following events one or two edges early. The bench also targets the delay clamp, which catches a design that counts delay values 5 to 7 literally. It covers a follow-mode event with sync enabled, which exposes a design that wrongly applies the delay there. An indefinite hold-off must stall the synchronized events forever. A second length-count pulse mid-sequence and a program pulse mid-sequence show whether a design restarts its edge count or keeps stale events alive.

// File: rtl/sus_pkg.sv
package sus_pkg;

    localparam int SEL_W   = 2;
    localparam int DLY_W   = 3;
    localparam int DLY_MAX = 4;
    localparam int CNT_W   = SEL_W + 1;
    localparam int EDGE_LIMIT = 1 << SEL_W;
    localparam int NUM_EV  = 3;

    localparam int EV_DONE = 0;
    localparam int EV_GSR  = 1;
    localparam int EV_IOE  = 2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_WAIT  = 2'd0,
        EV_ARMED = 2'd1,
        EV_HOLD  = 2'd2,
        EV_FIRED = 2'd3
    } ev_state_t;

    typedef struct packed {
        logic             follow;
        logic [SEL_W-1:0] edge_sel;
        logic             sync;
        logic [DLY_W-1:0] dly;
    } ev_cfg_t;

endpackage

// File: rtl/sus_sync.sv
module sus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sus_edge_ctr.sv
module sus_edge_ctr
    import sus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EDGE_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sus_event.sv
module sus_event
    import sus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pin_hi_i,
    input  ev_cfg_t          cfg_i,
    output logic             fired_o
);
    ev_state_t        state_q, state_d;
    logic [DLY_W-1:0] dcnt_q, dcnt_d;
    logic [DLY_W-1:0] eff_dly;
    logic             edge_hit;

    // Delay requests beyond the maximum are clamped.
    assign eff_dly  = (cfg_i.dly > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : cfg_i.dly;
    assign edge_hit = run_i && (cnt_i == {1'b0, cfg_i.edge_sel});

    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        unique case (state_q)
            EV_WAIT: begin
                if (run_i && cfg_i.follow) begin
                    if (pin_hi_i) begin
                        state_d = EV_FIRED;
                    end
                end else if (edge_hit) begin
                    state_d = cfg_i.sync ? EV_ARMED : EV_FIRED;
                end
            end
            EV_ARMED: begin
                if (pin_hi_i) begin
                    if (eff_dly == '0) begin
                        state_d = EV_FIRED;
                    end else begin
                        state_d = EV_HOLD;
                        dcnt_d  = DLY_W'(1);
                    end
                end
            end
            EV_HOLD: begin
                if (dcnt_q == eff_dly) begin
                    state_d = EV_FIRED;
                end else begin
                    dcnt_d = dcnt_q + 1'b1;
                end
            end
            EV_FIRED: begin
                state_d = EV_FIRED;
            end
            default: begin
                state_d = EV_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_WAIT;
            dcnt_q  <= '0;
        end else if (clr_i) begin
            state_q <= EV_WAIT;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
        end
    end

    always_comb begin
        fired_o = (state_q == EV_FIRED);
    end
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import sus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_i,
    input  logic       lc_met_i,
    input  logic       done_pin_i,
    input  logic [1:0] done_sel_i,
    input  logic [2:0] gsr_sel_i,
    input  logic [2:0] ioe_sel_i,
    input  logic       sync_en_i,
    input  logic [2:0] gsr_dly_i,
    input  logic [2:0] ioe_dly_i,
    output logic       done_rel_o,
    output logic       gsr_rel_o,
    output logic       ioe_en_o,
    output logic       finished_o
);
    seq_state_t       state_q, state_d;
    logic             pin_hi;
    logic             run;
    logic             start;
    logic [CNT_W-1:0] edge_cnt;
    logic [NUM_EV-1:0] fired;
    ev_cfg_t          cfg [NUM_EV];

    sus_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (done_pin_i),
        .sync_o  (pin_hi)
    );

    assign start = (state_q == SQ_IDLE) && lc_met_i && !prog_i;
    assign run   = (state_q == SQ_RUN);

    sus_edge_ctr u_edge_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start || prog_i),
        .run_i (run),
        .cnt_o (edge_cnt)
    );

    always_comb begin
        cfg[EV_DONE] = '{follow: 1'b0, edge_sel: done_sel_i, sync: 1'b0, dly: '0};
        cfg[EV_GSR]  = '{follow: gsr_sel_i[2], edge_sel: gsr_sel_i[1:0],
                         sync: sync_en_i, dly: gsr_dly_i};
        cfg[EV_IOE]  = '{follow: ioe_sel_i[2], edge_sel: ioe_sel_i[1:0],
                         sync: sync_en_i, dly: ioe_dly_i};
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        sus_event u_ev (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (prog_i),
            .run_i    (run),
            .cnt_i    (edge_cnt),
            .pin_hi_i (pin_hi),
            .cfg_i    (cfg[g]),
            .fired_o  (fired[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (lc_met_i) state_d = SQ_RUN;
            SQ_RUN:  if (&fired)   state_d = SQ_FIN;
            SQ_FIN:  state_d = SQ_FIN;
            default: state_d = SQ_IDLE;
        endcase
        if (prog_i) begin
            state_d = SQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done_rel_o = fired[EV_DONE];
        gsr_rel_o  = fired[EV_GSR];
        ioe_en_o   = fired[EV_IOE];
        finished_o = (state_q == SQ_FIN);
    end
endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_i,
    input logic       done_pin_i,
    input logic [2:0] gsr_sel_i,
    input logic [2:0] ioe_sel_i,
    input logic       done_rel_o,
    input logic       gsr_rel_o,
    input logic       ioe_en_o,
    input logic       finished_o
);
    p_sticky_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_rel_o && !prog_i |=> done_rel_o);
    p_sticky_gsr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_rel_o && !prog_i |=> gsr_rel_o);
    p_sticky_ioe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ioe_en_o && !prog_i |=> ioe_en_o);

    p_prog_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> !done_rel_o && !gsr_rel_o && !ioe_en_o && !finished_o);

    p_finish_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> done_rel_o && gsr_rel_o && ioe_en_o);

    p_follow_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gsr_rel_o) && gsr_sel_i[2] |-> done_rel_o);
    p_follow_ioe_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ioe_en_o) && ioe_sel_i[2] |-> done_rel_o);

    // R7: a pin seen low two edges back cannot have released a follow event.
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_sel_i[2] && !gsr_rel_o && !$past(done_pin_i, 2) |=> !gsr_rel_o);
endmodule

bind startup_sequencer startup_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_i     (prog_i),
    .done_pin_i (done_pin_i),
    .gsr_sel_i  (gsr_sel_i),
    .ioe_sel_i  (ioe_sel_i),
    .done_rel_o (done_rel_o),
    .gsr_rel_o  (gsr_rel_o),
    .ioe_en_o   (ioe_en_o),
    .finished_o (finished_o)
);

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;
    localparam int NEVER  = 31;
    localparam int WINDOW = 24;
    localparam int NVEC   = 8;

    typedef struct packed {
        logic [1:0] ds;
        logic [2:0] gs;
        logic [2:0] is;
        logic       sy;
        logic [2:0] gd;
        logic [2:0] id;
        logic [4:0] h;
        logic [4:0] ed;
        logic [4:0] eg;
        logic [4:0] ei;
        logic [4:0] ef;
    } vec_t;

    // Expected rise edges worked out from R3..R9 (31 = never in window).
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd4, 3'd4, 1'b0, 3'd0, 3'd0, 5'd0,  5'd1, 5'd4,  5'd4,  5'd5},
        '{2'd3, 3'd0, 3'd2, 1'b0, 3'd0, 3'd0, 5'd0,  5'd4, 5'd1,  5'd3,  5'd5},
        '{2'd1, 3'd1, 3'd3, 1'b1, 3'd0, 3'd2, 5'd0,  5'd2, 5'd5,  5'd7,  5'd8},
        '{2'd0, 3'd4, 3'd0, 1'b1, 3'd0, 3'd1, 5'd10, 5'd1, 5'd13, 5'd14, 5'd15},
        '{2'd2, 3'd3, 3'd4, 1'b1, 3'd0, 3'd4, 5'd0,  5'd3, 5'd6,  5'd6,  5'd7},
        '{2'd0, 3'd0, 3'd1, 1'b1, 3'd7, 3'd3, 5'd0,  5'd1, 5'd8,  5'd7,  5'd9},
        '{2'd0, 3'd4, 3'd0, 1'b0, 3'd0, 3'd0, 5'd5,  5'd1, 5'd8,  5'd1,  5'd9},
        '{2'd0, 3'd4, 3'd1, 1'b1, 3'd0, 3'd0, 5'd31, 5'd1, 5'd31, 5'd31, 5'd31}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_i = 1'b0;
    logic       lc_met_i = 1'b0;
    logic       hold = 1'b0;
    logic       done_pin_i;
    logic [1:0] done_sel_i = '0;
    logic [2:0] gsr_sel_i = '0;
    logic [2:0] ioe_sel_i = '0;
    logic       sync_en_i = 1'b0;
    logic [2:0] gsr_dly_i = '0;
    logic [2:0] ioe_dly_i = '0;
    logic       done_rel_o, gsr_rel_o, ioe_en_o, finished_o;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    always #10 clk = ~clk;

    // Wire-AND of the DONE line: released by the block, held off by the bench.
    assign done_pin_i = done_rel_o & ~hold;

    startup_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_i     (prog_i),
        .lc_met_i   (lc_met_i),
        .done_pin_i (done_pin_i),
        .done_sel_i (done_sel_i),
        .gsr_sel_i  (gsr_sel_i),
        .ioe_sel_i  (ioe_sel_i),
        .sync_en_i  (sync_en_i),
        .gsr_dly_i  (gsr_dly_i),
        .ioe_dly_i  (ioe_dly_i),
        .done_rel_o (done_rel_o),
        .gsr_rel_o  (gsr_rel_o),
        .ioe_en_o   (ioe_en_o),
        .finished_o (finished_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input vec_t v, input int relc,
                           output int fd, output int fg, output int fi,
                           output int ff, output bit drop);
        @(negedge clk);
        prog_i = 1'b1;
        lc_met_i = 1'b0;
        done_sel_i = v.ds; gsr_sel_i = v.gs; ioe_sel_i = v.is;
        sync_en_i = v.sy; gsr_dly_i = v.gd; ioe_dly_i = v.id;
        hold = (v.h != 0);
        @(negedge clk);
        prog_i = 1'b0;
        @(negedge clk);
        lc_met_i = 1'b1;
        @(negedge clk);
        lc_met_i = 1'b0;
        fd = NEVER; fg = NEVER; fi = NEVER; ff = NEVER; drop = 0;
        for (int k = 1; k <= WINDOW; k++) begin
            @(negedge clk);
            if (done_rel_o && fd == NEVER) fd = k;
            if (gsr_rel_o  && fg == NEVER) fg = k;
            if (ioe_en_o   && fi == NEVER) fi = k;
            if (finished_o && ff == NEVER) ff = k;
            if ((!done_rel_o && fd != NEVER) || (!gsr_rel_o && fg != NEVER) ||
                (!ioe_en_o && fi != NEVER)) drop = 1;
            lc_met_i = (relc != 0) && (k + 1 == relc);
            if (k == int'(v.h)) hold = 1'b0;
        end
        lc_met_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!reported) begin
            reported = 1;
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fd, fg, fi, ff;
        bit drop;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {done_rel_o, gsr_rel_o, ioe_en_o, finished_o}, 0);

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            run_seq(VECS[i], 0, fd, fg, fi, ff, drop);
            chk($sformatf("R3 vec%0d done edge", i), fd, int'(VECS[i].ed));
            chk($sformatf("R4/R5/R6/R7 vec%0d gsr edge", i), fg, int'(VECS[i].eg));
            chk($sformatf("R4/R5/R6/R7 vec%0d ioe edge", i), fi, int'(VECS[i].ei));
            chk($sformatf("R9 vec%0d finished edge", i), ff, int'(VECS[i].ef));
            chk($sformatf("R8 vec%0d sticky", i), int'(drop), 0);
        end

        // R2: second length-count pulse at edge 3 must not renumber edges
        run_seq(VECS[1], 3, fd, fg, fi, ff, drop);
        chk("R2 repeat lc done edge", fd, 4);
        chk("R2 repeat lc finished edge", ff, 5);

        // R10: program mid-sequence clears everything
        @(negedge clk);
        prog_i = 1'b1;
        done_sel_i = 2'd0; gsr_sel_i = 3'd4; ioe_sel_i = 3'd4;
        sync_en_i = 1'b0; hold = 1'b0;
        @(negedge clk);
        prog_i = 1'b0;
        lc_met_i = 1'b1;
        @(negedge clk);
        lc_met_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 pre-program done high", int'(done_rel_o), 1);
        prog_i = 1'b1;
        @(negedge clk);
        prog_i = 1'b0;
        chk("R10 program clears", {done_rel_o, gsr_rel_o, ioe_en_o, finished_o}, 0);

        // R1: no restart without a new length-count pulse
        repeat (10) @(negedge clk);
        chk("R1 idle without lc", {done_rel_o, gsr_rel_o, ioe_en_o, finished_o}, 0);

        // R1: a fresh pulse restarts the sequence from edge 1
        lc_met_i = 1'b1;
        @(negedge clk);
        lc_met_i = 1'b0;
        @(negedge clk);
        chk("R1 restart done at edge 1", int'(done_rel_o), 1);
        repeat (4) @(negedge clk);
        chk("R9 restart finished", int'(finished_o), 1);

        // R10: program after finish
        prog_i = 1'b1;
        @(negedge clk);
        prog_i = 1'b0;
        chk("R10 program after finish", {done_rel_o, gsr_rel_o, ioe_en_o, finished_o}, 0);

        if (!reported) begin
            reported = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule